// File: doc/BRIEF.md
# Thread Context CAM Matcher

This block decides whether one hardware thread is the destination of an interrupt notification. It takes a notification target, made of a format bit, a block number, an index, an ignore flag and a logical server number. It compares that target with the thread's context registers. For each privilege ring there is a valid bit, and for some rings a stored CAM value or server number. The block reports which ring of the thread the target hits, or that it hits none.

The thread also has its own physical CAM line. The block builds it from the chip block id and the processor id, with the thread id taken as 7 or 8 bits depending on a mode input. It offers that line as an output. The matching logic is combinational. A parameter puts one register stage in front of all outputs, and that stage is on by default.

A notification router puts one instance beside each thread's context. It takes the winning ring from `hit_ring` whenever `hit_vld` is high.

Top module: `thread_cam_matcher`

## Requirements
- R1: While `rst` is high at a clock edge, the registered outputs `hit_vld`, `hit_ring`, `unsup` and `own_cam` all become zero.
- R2: With `tgt_fmt`=0 and `tgt_ign`=1, the result has `hit_vld`=0 and `unsup`=1, whatever the context registers hold.
- R3: With `tgt_fmt`=0 and `tgt_ign`=0, the rings are tried in a fixed order: physical (code 3), then pool (code 2), then OS (code 1). The first ring that is valid and whose CAM equals the 24-bit target `{tgt_blk, tgt_idx}` is reported in `hit_ring`, with `hit_vld`=1.
- R4: The index field `own_cam[19:0]` of the thread's physical CAM line is `(1<<w) | (proc_id & ((1<<w)-1))`. The width w is 8 when `tid8_mode`=1 and 7 when `tid8_mode`=0. With `proc_id`=8'hA3 this gives 20'h000A3 in 7-bit mode and 20'h001A3 in 8-bit mode.
- R5: The block field `own_cam[23:20]` equals `chip_blk`.
- R6: With `tgt_fmt`=1, the only possible hit is the user ring, code 0. It needs all four of these: `os_vld`=1, `os_cam` equal to the target, `usr_vld`=1, and `usr_lsn` equal to `tgt_lsn`.
- R7: When no ring matches and the request is supported, the result is `hit_vld`=0, `hit_ring`=0 and `unsup`=0. A "no match" result therefore never carries `hit_vld`=1, and so it differs from every ring code.
- R8: With `tgt_fmt`=1, a matching physical or pool ring has no effect. The result is no match unless the user-ring conditions of R6 hold.
- R9: With `REG_OUT`=1, the outputs show the result for the inputs present at the previous rising clock edge. A change of input is not visible before that edge.
- R10: With `tgt_fmt`=1, `tgt_ign` has no effect. A full user match still reports code 0 with `unsup`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_fmt | input | 1 | Target format: 0 = thread target, 1 = user-level target |
| tgt_blk | input | BLK_W (4) | Target block number |
| tgt_idx | input | IDX_W (20) | Target index |
| tgt_ign | input | 1 | Target ignore flag (low index bits ignored; not supported) |
| tgt_lsn | input | LSN_W (12) | Target logical server number |
| phys_vld | input | 1 | Physical ring valid |
| pool_vld | input | 1 | Pool ring valid |
| pool_cam | input | BLK_W+IDX_W | Pool ring stored CAM value |
| os_vld | input | 1 | OS ring valid |
| os_cam | input | BLK_W+IDX_W | OS ring stored CAM value |
| usr_vld | input | 1 | User ring valid |
| usr_lsn | input | LSN_W | User ring stored logical server number |
| chip_blk | input | BLK_W | Block id of this chip |
| proc_id | input | PID_W (8) | Processor id of the thread |
| tid8_mode | input | 1 | 1 = 8-bit thread id, 0 = 7-bit thread id |
| hit_vld | output | 1 | A ring matched |
| hit_ring | output | 2 | Matching ring: 0 user, 1 OS, 2 pool, 3 physical |
| unsup | output | 1 | Request form not supported |
| own_cam | output | BLK_W+IDX_W | The thread's physical CAM line |

## Verification
Suppose the priority chain is broken, for example the pool ring is tried before the physical ring, or a valid bit is dropped. Then `hit_ring` shows the wrong code, or `hit_vld` goes wrong, one cycle after the input pattern that exposes the fault. The same holds if the user path leaves out its OS-CAM or server-number term: a mismatched request then hits, and this shows at the next output edge. A thread-id width that is taken from the wrong mode shows in `own_cam` in that same cycle. It also turns a physical-ring match into a lower ring or into no match.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  typedef enum logic [1:0] {
    RING_USER = 2'd0,
    RING_OS   = 2'd1,
    RING_POOL = 2'd2,
    RING_PHYS = 2'd3
  } ring_e;
endpackage

// File: rtl/tcm_hwcam.sv
module tcm_hwcam #(
  parameter int BLK_W = 4,
  parameter int IDX_W = 20,
  parameter int PID_W = 8
) (
  input  logic [BLK_W-1:0]       chip_blk,
  input  logic [PID_W-1:0]       proc_id,
  input  logic                   tid8_mode,
  output logic [BLK_W+IDX_W-1:0] cam_line
);
  localparam int TID_WIDE   = PID_W;
  localparam int TID_NARROW = PID_W - 1;

  logic [IDX_W-1:0] idx;

  // Marker bit sits just above the thread id; its position follows the mode.
  always_comb begin
    idx = '0;
    if (tid8_mode) begin
      idx[TID_WIDE]         = 1'b1;
      idx[TID_WIDE-1:0]     = proc_id;
    end else begin
      idx[TID_NARROW]       = 1'b1;
      idx[TID_NARROW-1:0]   = proc_id[TID_NARROW-1:0];
    end
  end

  assign cam_line = {chip_blk, idx};
endmodule

// File: rtl/tcm_ring_cmp.sv
module tcm_ring_cmp #(
  parameter int W = 24
) (
  input  logic         vld,
  input  logic [W-1:0] stored,
  input  logic [W-1:0] target,
  output logic         hit
);
  assign hit = vld && (stored == target);
endmodule

// File: rtl/tcm_prio.sv
module tcm_prio
  import tcm_pkg::*;
(
  input  logic       fmt,
  input  logic       ign,
  input  logic [3:0] cand_hit,   // indexed by ring code
  output logic       vld,
  output ring_e      ring,
  output logic       unsup
);
  always_comb begin
    vld   = 1'b0;
    ring  = RING_USER;
    unsup = 1'b0;
    if (!fmt) begin
      if (ign) begin
        unsup = 1'b1;
      end else if (cand_hit[RING_PHYS]) begin
        vld  = 1'b1;
        ring = RING_PHYS;
      end else if (cand_hit[RING_POOL]) begin
        vld  = 1'b1;
        ring = RING_POOL;
      end else if (cand_hit[RING_OS]) begin
        vld  = 1'b1;
        ring = RING_OS;
      end
    end else if (cand_hit[RING_USER]) begin
      vld  = 1'b1;
      ring = RING_USER;
    end
  end
endmodule

// File: rtl/thread_cam_matcher.sv
module thread_cam_matcher
  import tcm_pkg::*;
#(
  parameter int BLK_W   = 4,
  parameter int IDX_W   = 20,
  parameter int LSN_W   = 12,
  parameter int PID_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tgt_fmt,
  input  logic [BLK_W-1:0]       tgt_blk,
  input  logic [IDX_W-1:0]       tgt_idx,
  input  logic                   tgt_ign,
  input  logic [LSN_W-1:0]       tgt_lsn,
  input  logic                   phys_vld,
  input  logic                   pool_vld,
  input  logic [BLK_W+IDX_W-1:0] pool_cam,
  input  logic                   os_vld,
  input  logic [BLK_W+IDX_W-1:0] os_cam,
  input  logic                   usr_vld,
  input  logic [LSN_W-1:0]       usr_lsn,
  input  logic [BLK_W-1:0]       chip_blk,
  input  logic [PID_W-1:0]       proc_id,
  input  logic                   tid8_mode,
  output logic                   hit_vld,
  output logic [1:0]             hit_ring,
  output logic                   unsup,
  output logic [BLK_W+IDX_W-1:0] own_cam
);
  localparam int CAM_W = BLK_W + IDX_W;

  logic [CAM_W-1:0] tgt_cam;
  logic [CAM_W-1:0] hw_cam;
  logic [CAM_W-1:0] ring_cam [1:3];
  logic [3:1]       ring_vld;
  logic [3:0]       cand_hit;
  logic             lsn_hit;

  logic             c_vld;
  ring_e            c_ring;
  logic             c_unsup;

  assign tgt_cam = {tgt_blk, tgt_idx};

  tcm_hwcam #(.BLK_W(BLK_W), .IDX_W(IDX_W), .PID_W(PID_W)) u_hwcam (
    .chip_blk (chip_blk),
    .proc_id  (proc_id),
    .tid8_mode(tid8_mode),
    .cam_line (hw_cam)
  );

  assign ring_cam[RING_OS]   = os_cam;
  assign ring_cam[RING_POOL] = pool_cam;
  assign ring_cam[RING_PHYS] = hw_cam;
  assign ring_vld[RING_OS]   = os_vld;
  assign ring_vld[RING_POOL] = pool_vld;
  assign ring_vld[RING_PHYS] = phys_vld;

  for (genvar k = 1; k <= 3; k++) begin : g_ring
    tcm_ring_cmp #(.W(CAM_W)) u_cmp (
      .vld   (ring_vld[k]),
      .stored(ring_cam[k]),
      .target(tgt_cam),
      .hit   (cand_hit[k])
    );
  end

  tcm_ring_cmp #(.W(LSN_W)) u_lsn_cmp (
    .vld   (usr_vld),
    .stored(usr_lsn),
    .target(tgt_lsn),
    .hit   (lsn_hit)
  );

  // User path needs the OS context match as well as the server number.
  assign cand_hit[RING_USER] = cand_hit[RING_OS] && lsn_hit;

  tcm_prio u_prio (
    .fmt     (tgt_fmt),
    .ign     (tgt_ign),
    .cand_hit(cand_hit),
    .vld     (c_vld),
    .ring    (c_ring),
    .unsup   (c_unsup)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        hit_vld  <= 1'b0;
        hit_ring <= 2'd0;
        unsup    <= 1'b0;
        own_cam  <= '0;
      end else begin
        hit_vld  <= c_vld;
        hit_ring <= c_ring;
        unsup    <= c_unsup;
        own_cam  <= hw_cam;
      end
    end
  end else begin : g_comb
    assign hit_vld  = c_vld;
    assign hit_ring = c_ring;
    assign unsup    = c_unsup;
    assign own_cam  = hw_cam;
  end
endmodule

// File: rtl/tcm_chk.sv
module tcm_chk #(
  parameter int BLK_W   = 4,
  parameter int IDX_W   = 20,
  parameter int PID_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   tgt_fmt,
  input logic                   tgt_ign,
  input logic [BLK_W-1:0]       tgt_blk,
  input logic [IDX_W-1:0]       tgt_idx,
  input logic                   phys_vld,
  input logic [BLK_W-1:0]       chip_blk,
  input logic [PID_W-1:0]       proc_id,
  input logic                   tid8_mode,
  input logic                   hit_vld,
  input logic [1:0]             hit_ring,
  input logic                   unsup,
  input logic [BLK_W+IDX_W-1:0] own_cam
);
  localparam int CAM_W = BLK_W + IDX_W;

  if (REG_OUT) begin : g_chk
    logic armed;
    always_ff @(posedge clk) begin
      if (rst) armed <= 1'b0;
      else     armed <= 1'b1;
    end

    assert_unsup_R2: assert property (@(posedge clk) disable iff (rst)
      (armed && !$past(tgt_fmt) && $past(tgt_ign)) |-> (unsup && !hit_vld));

    assert_phys_first_R3: assert property (@(posedge clk) disable iff (rst)
      (armed && !$past(tgt_fmt) && !$past(tgt_ign) && $past(phys_vld) &&
       ($past({tgt_blk, tgt_idx}) == own_cam)) |-> (hit_vld && hit_ring == 2'd3));

    assert_wide_tid_R4: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(tid8_mode)) |->
        (own_cam[PID_W] && own_cam[PID_W-1:0] == $past(proc_id) &&
         own_cam[IDX_W-1:PID_W+1] == '0));

    assert_block_R5: assert property (@(posedge clk) disable iff (rst)
      armed |-> (own_cam[CAM_W-1:IDX_W] == $past(chip_blk)));

    assert_user_only_R6: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(tgt_fmt) && hit_vld) |-> (hit_ring == 2'd0));

    assert_fmt1_supported_R10: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(tgt_fmt)) |-> !unsup);

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
      hit_vld |-> !unsup);
  end
endmodule

bind thread_cam_matcher tcm_chk #(
  .BLK_W(BLK_W), .IDX_W(IDX_W), .PID_W(PID_W), .REG_OUT(REG_OUT)
) u_tcm_chk (
  .clk(clk), .rst(rst), .tgt_fmt(tgt_fmt), .tgt_ign(tgt_ign),
  .tgt_blk(tgt_blk), .tgt_idx(tgt_idx), .phys_vld(phys_vld),
  .chip_blk(chip_blk), .proc_id(proc_id), .tid8_mode(tid8_mode),
  .hit_vld(hit_vld), .hit_ring(hit_ring), .unsup(unsup), .own_cam(own_cam)
);

// File: tb/tb_thread_cam_matcher.sv
`timescale 1ns/1ps
module tb_thread_cam_matcher;
  logic        clk = 1'b0;
  logic        rst;
  logic        tgt_fmt, tgt_ign;
  logic [3:0]  tgt_blk;
  logic [19:0] tgt_idx;
  logic [11:0] tgt_lsn;
  logic        phys_vld, pool_vld, os_vld, usr_vld;
  logic [23:0] pool_cam, os_cam;
  logic [11:0] usr_lsn;
  logic [3:0]  chip_blk;
  logic [7:0]  proc_id;
  logic        tid8_mode;
  logic        hit_vld, unsup;
  logic [1:0]  hit_ring;
  logic [23:0] own_cam;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  thread_cam_matcher dut (
    .clk(clk), .rst(rst), .tgt_fmt(tgt_fmt), .tgt_blk(tgt_blk),
    .tgt_idx(tgt_idx), .tgt_ign(tgt_ign), .tgt_lsn(tgt_lsn),
    .phys_vld(phys_vld), .pool_vld(pool_vld), .pool_cam(pool_cam),
    .os_vld(os_vld), .os_cam(os_cam), .usr_vld(usr_vld), .usr_lsn(usr_lsn),
    .chip_blk(chip_blk), .proc_id(proc_id), .tid8_mode(tid8_mode),
    .hit_vld(hit_vld), .hit_ring(hit_ring), .unsup(unsup), .own_cam(own_cam)
  );

  task automatic check_res(string req, logic ev, logic [1:0] er, logic eu);
    n_chk++;
    if (hit_vld !== ev || hit_ring !== er || unsup !== eu) begin
      n_bad++;
      $display("FAIL %s: got vld=%0b ring=%0d unsup=%0b, expected vld=%0b ring=%0d unsup=%0b",
               req, hit_vld, hit_ring, unsup, ev, er, eu);
    end
  endtask

  task automatic check_cam(string req, logic [23:0] exp);
    n_chk++;
    if (own_cam !== exp) begin
      n_bad++;
      $display("FAIL %s: got own_cam=%h, expected %h", req, own_cam, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clear_ctx();
    @(negedge clk);
    tgt_fmt = 0; tgt_ign = 0; tgt_blk = 4'h5; tgt_idx = 20'h000A3; tgt_lsn = 12'h0;
    phys_vld = 0; pool_vld = 0; os_vld = 0; usr_vld = 0;
    pool_cam = 24'h0; os_cam = 24'h0; usr_lsn = 12'h0;
    chip_blk = 4'h5; proc_id = 8'hA3; tid8_mode = 0;
  endtask

  task automatic t_reset();
    clear_ctx(); phys_vld = 1; rst = 1;
    step(); step();
    check_res("R1", 0, 0, 0);
    check_cam("R1", 24'h0);
    @(negedge clk); rst = 0;
  endtask

  task automatic t_prio();
    clear_ctx();
    phys_vld = 1; pool_vld = 1; pool_cam = 24'h5000A3; os_vld = 1; os_cam = 24'h5000A3;
    step(); check_res("R3 phys first", 1, 3, 0);
    check_cam("R4 7-bit", 24'h5000A3);
    check_cam("R5 block", 24'h5000A3);
    @(negedge clk); phys_vld = 0;
    step(); check_res("R3 pool second", 1, 2, 0);
    @(negedge clk); pool_vld = 0;
    step(); check_res("R3 os third", 1, 1, 0);
    @(negedge clk); os_cam = 24'h5000A4;
    step(); check_res("R7 no match", 0, 0, 0);
    @(negedge clk); os_vld = 0; os_cam = 24'h5000A3;
    step(); check_res("R7 invalid os", 0, 0, 0);
  endtask

  task automatic t_mode8();
    clear_ctx();
    tid8_mode = 1; chip_blk = 4'h9; phys_vld = 1;
    pool_vld = 1; pool_cam = 24'h5000A3;
    step(); check_cam("R4 8-bit", 24'h9001A3);
    check_res("R3 phys miss falls to pool", 1, 2, 0);
    @(negedge clk); tgt_blk = 4'h9; tgt_idx = 20'h001A3;
    step(); check_res("R5 phys uses chip block", 1, 3, 0);
  endtask

  task automatic t_ignore();
    clear_ctx();
    phys_vld = 1; tgt_ign = 1;
    step(); check_res("R2", 0, 0, 1);
  endtask

  task automatic t_user();
    clear_ctx();
    tgt_fmt = 1; tgt_blk = 4'h2; tgt_idx = 20'h00456; tgt_lsn = 12'h3C1;
    os_vld = 1; os_cam = 24'h200456; usr_vld = 1; usr_lsn = 12'h3C1;
    step(); check_res("R6 full user match", 1, 0, 0);
    @(negedge clk); usr_lsn = 12'h3C0;
    step(); check_res("R6 lsn mismatch", 0, 0, 0);
    @(negedge clk); usr_lsn = 12'h3C1; usr_vld = 0;
    step(); check_res("R6 user invalid", 0, 0, 0);
    @(negedge clk); usr_vld = 1; os_cam = 24'h200457;
    step(); check_res("R6 os cam mismatch", 0, 0, 0);
    @(negedge clk); os_cam = 24'h200456; os_vld = 0;
    step(); check_res("R6 os invalid", 0, 0, 0);
    @(negedge clk); os_vld = 1; tgt_ign = 1;
    step(); check_res("R10 ignore flag in format 1", 1, 0, 0);
  endtask

  task automatic t_fmt1_other_rings();
    clear_ctx();
    tgt_fmt = 1; phys_vld = 1; pool_vld = 1; pool_cam = 24'h5000A3;
    step(); check_res("R8", 0, 0, 0);
  endtask

  task automatic t_latency();
    clear_ctx();
    step(); check_res("R9 idle", 0, 0, 0);
    @(negedge clk); pool_vld = 1; pool_cam = 24'h5000A3;
    #1; check_res("R9 before edge", 0, 0, 0);
    step(); check_res("R9 after edge", 1, 2, 0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1;
    t_reset();
    t_prio();
    t_mode8();
    t_ignore();
    t_user();
    t_fmt1_other_rings();
    t_latency();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule